// File: doc/BRIEF.md
# PCM Voice Slot Serializer/Deserializer

This block moves one voice sample per frame across a serial PCM data line. On the transmit side it takes a parallel sample, places it in the one active slot of the frame according to the selected format, and shifts it out one bit per bit-clock period. On the receive side it collects the bits of the same slot from the input line and returns them as a parallel sample, aligned in the same format, with a one-cycle valid strobe.

The bit clock and frame sync are either generated from the system clock (master) or taken from the pins (slave). In slave mode both lines, and the received data, pass through two-flop synchronizers, and their edges are found against the system clock. A frame starts when the sync is seen high at a falling bit-clock edge after having been low at the previous one. The first slot bit is driven on the next rising edge. Transmit bits change on rising edges and receive bits are sampled on falling edges. Sample format, fill mode and bit order are taken when the frame starts and hold for the whole slot. Mute and the output-release controls act live.

Top module: `pcm_slot_codec`

## Requirements
- R1: `cfg_fmt` selects the slot layout: 2'b00 is a 13-bit sample in a 16-bit slot, 2'b01 a 16-bit sample in a 16-bit slot, 2'b10 an 8-bit sample in a 16-bit slot and 2'b11 an 8-bit sample in an 8-bit slot. Samples use the low bits of `tx_sample`.
- R2: With `cfg_sext` = 0, an 8-bit or 13-bit sample in a 16-bit slot occupies the upper slot bits, and the low bits below it are zeros (8 zeros for an 8-bit sample, 3 for a 13-bit sample).
- R3: With `cfg_sext` = 1, an 8-bit or 13-bit sample in a 16-bit slot occupies the low slot bits, and the bits above it repeat its top bit.
- R4: `cfg_lsb_first` = 0 sends and receives the slot word from its top bit down. `cfg_lsb_first` = 1 sends and receives it from bit 0 up.
- R5: While `cfg_mute` is 1, `pcm_out` is 0.
- R6: While `cfg_tri_en` is 0, `pcm_oe` is 1 at all times. Outside the slot, `pcm_out` is 0.
- R7: With `cfg_tri_en` = 1, `pcm_oe` is 1 from the first slot bit. It falls at the falling bit-clock edge inside the last slot bit when `cfg_tri_rise` = 0, and at the rising edge that ends the last slot bit when `cfg_tri_rise` = 1.
- R8: If a new frame starts right after the last slot bit, `pcm_oe` is not released.
- R9: A frame starts at the falling bit-clock edge where sync is high after being low at the previous falling edge. Slot bit 0 is driven on the next rising edge, and every later bit is driven on the following rising edge. `tx_take` pulses for one cycle when `tx_sample` is captured at the frame start.
- R10: At the falling edge of the last slot bit, `rx_valid` pulses for one cycle. `rx_sample` then carries the received sample, zero-extended, in the same format, so that a looped-back line returns the transmitted sample bits.
- R11: In master mode, `bclk_o` has a period of 2*CLK_HALF system clocks. `sync_o` rises with `bclk_o` and stays high for one bit period once every FRAME_BITS bit periods.
- R12: In slave mode (`cfg_slave` = 1), timing comes from `ext_bclk` and `ext_sync` after synchronization, received data comes from the synchronized `pcm_in`, and `bclk_o` and `sync_o` are held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_slave | input | 1 | 1 takes bit clock and sync from the pins |
| cfg_fmt | input | 2 | Sample/slot format code |
| cfg_sext | input | 1 | Fill select: 0 zero low bits, 1 sign extension |
| cfg_lsb_first | input | 1 | Bit order of the slot word |
| cfg_mute | input | 1 | Forces the data output to 0 |
| cfg_tri_en | input | 1 | Releases the output after the slot |
| cfg_tri_rise | input | 1 | Release on rising (1) or falling (0) edge |
| tx_sample | input | 16 | Parallel sample to send |
| tx_take | output | 1 | Pulse when tx_sample is captured |
| rx_sample | output | 16 | Received parallel sample |
| rx_valid | output | 1 | One-cycle strobe for rx_sample |
| ext_bclk | input | 1 | External bit clock (slave) |
| ext_sync | input | 1 | External frame sync (slave) |
| bclk_o | output | 1 | Generated bit clock (master) |
| sync_o | output | 1 | Generated frame sync (master) |
| pcm_in | input | 1 | Serial receive data |
| pcm_out | output | 1 | Serial transmit data |
| pcm_oe | output | 1 | Output enable for pcm_out |

## Verification
The data line is looped back, and each format is sent with both fill modes. The samples use asymmetric bit patterns, so a swapped fill, a wrong shift length or a reversed order changes both the serial bits and the returned sample. The same sample is also sent MSB-first and LSB-first, which shows whether the order reverses over the whole slot width or over the sample width only. Release timing is tried with both edge choices, in master frames that have idle bits after the slot and in slave frames that follow one another with no gap. This separates an early or late release from one that wrongly cuts a following slot. Mute is applied on its own, so that forced zeros can be told apart from a stuck output.

// File: rtl/pcm_slot_codec.sv
module pcm_slot_codec #(
  parameter int CLK_HALF   = 2,
  parameter int FRAME_BITS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_slave,
  input  logic [1:0]  cfg_fmt,
  input  logic        cfg_sext,
  input  logic        cfg_lsb_first,
  input  logic        cfg_mute,
  input  logic        cfg_tri_en,
  input  logic        cfg_tri_rise,
  input  logic [15:0] tx_sample,
  output logic        tx_take,
  output logic [15:0] rx_sample,
  output logic        rx_valid,
  input  logic        ext_bclk,
  input  logic        ext_sync,
  output logic        bclk_o,
  output logic        sync_o,
  input  logic        pcm_in,
  output logic        pcm_out,
  output logic        pcm_oe
);

  localparam int DIVW = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;
  localparam int FCW  = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;

  logic [DIVW-1:0] div_q;
  logic [FCW-1:0]  fcnt_q;
  logic            bclk_q, sync_q;
  logic [2:0]      bs_q;
  logic [1:0]      ss_q, ds_q;

  wire div_end = (div_q == DIVW'(CLK_HALF - 1));
  wire m_rise  = ~cfg_slave & div_end & ~bclk_q;
  wire m_fall  = ~cfg_slave & div_end &  bclk_q;
  wire s_rise  =  cfg_slave & bs_q[1] & ~bs_q[2];
  wire s_fall  =  cfg_slave & ~bs_q[1] & bs_q[2];
  wire rise    = m_rise | s_rise;
  wire fall    = m_fall | s_fall;
  wire sync_smp = cfg_slave ? ss_q[1] : sync_q;
  wire din_smp  = cfg_slave ? ds_q[1] : pcm_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      fcnt_q <= '0;
      bclk_q <= 1'b0;
      sync_q <= 1'b0;
    end else if (cfg_slave) begin
      div_q  <= '0;
      fcnt_q <= '0;
      bclk_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      div_q <= div_end ? '0 : div_q + 1'b1;
      if (div_end) bclk_q <= ~bclk_q;
      if (m_rise) begin
        fcnt_q <= (fcnt_q == FCW'(FRAME_BITS - 1)) ? '0 : fcnt_q + 1'b1;
        sync_q <= (fcnt_q == FCW'(FRAME_BITS - 1));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bs_q <= '0;
      ss_q <= '0;
      ds_q <= '0;
    end else begin
      bs_q <= {bs_q[1:0], ext_bclk};
      ss_q <= {ss_q[0], ext_sync};
      ds_q <= {ds_q[0], pcm_in};
    end
  end

  logic [15:0] txw_q, rxw_q, tx_fmt, rx_next, rx_fmt;
  logic [1:0]  fmt_q;
  logic        sext_q, lsb_q, pend_q, act_q, drive_q, data_q, sprev_q;
  logic [3:0]  idx_q;

  wire [3:0] last    = (fmt_q == 2'b11) ? 4'd7 : 4'd15;
  wire       at_last = act_q & (idx_q == last);
  wire       start   = fall & sync_smp & ~sprev_q;
  wire [3:0] idx_nx  = idx_q + 4'd1;

  function automatic logic [3:0] bitpos(input logic [3:0] k, input logic lsb, input logic [3:0] lst);
    return lsb ? k : lst - k;
  endfunction

  always_comb begin
    unique case (cfg_fmt)
      2'b00:   tx_fmt = cfg_sext ? {{3{tx_sample[12]}}, tx_sample[12:0]} : {tx_sample[12:0], 3'b000};
      2'b01:   tx_fmt = tx_sample;
      2'b10:   tx_fmt = cfg_sext ? {{8{tx_sample[7]}}, tx_sample[7:0]} : {tx_sample[7:0], 8'h00};
      default: tx_fmt = {8'h00, tx_sample[7:0]};
    endcase
  end

  always_comb begin
    rx_next = rxw_q;
    rx_next[bitpos(idx_q, lsb_q, last)] = din_smp;
    unique case (fmt_q)
      2'b00:   rx_fmt = sext_q ? {3'b000, rx_next[12:0]} : {3'b000, rx_next[15:3]};
      2'b01:   rx_fmt = rx_next;
      2'b10:   rx_fmt = sext_q ? {8'h00, rx_next[7:0]} : {8'h00, rx_next[15:8]};
      default: rx_fmt = {8'h00, rx_next[7:0]};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txw_q <= '0;  rxw_q <= '0;  fmt_q <= 2'b01;
      sext_q <= 1'b0; lsb_q <= 1'b0; pend_q <= 1'b0; act_q <= 1'b0;
      drive_q <= 1'b0; data_q <= 1'b0; sprev_q <= 1'b0; idx_q <= '0;
      tx_take <= 1'b0; rx_valid <= 1'b0; rx_sample <= '0;
    end else begin
      tx_take  <= 1'b0;
      rx_valid <= 1'b0;
      if (fall) begin
        sprev_q <= sync_smp;
        if (act_q) rxw_q <= rx_next;
        if (at_last) begin
          rx_valid  <= 1'b1;
          rx_sample <= rx_fmt;
          if (cfg_tri_en && !cfg_tri_rise && !start) drive_q <= 1'b0;
        end
        if (start) begin
          pend_q  <= 1'b1;
          txw_q   <= tx_fmt;
          fmt_q   <= cfg_fmt;
          sext_q  <= cfg_sext;
          lsb_q   <= cfg_lsb_first;
          tx_take <= 1'b1;
        end
      end
      if (rise) begin
        if (pend_q) begin
          pend_q  <= 1'b0;
          act_q   <= 1'b1;
          idx_q   <= '0;
          drive_q <= 1'b1;
          data_q  <= txw_q[bitpos(4'd0, lsb_q, last)];
        end else if (act_q) begin
          if (idx_q == last) begin
            act_q  <= 1'b0;
            data_q <= 1'b0;
            if (cfg_tri_en && cfg_tri_rise) drive_q <= 1'b0;
          end else begin
            idx_q  <= idx_nx;
            data_q <= txw_q[bitpos(idx_nx, lsb_q, last)];
          end
        end
      end
    end
  end

  assign bclk_o  = bclk_q;
  assign sync_o  = sync_q;
  assign pcm_oe  = ~cfg_tri_en | drive_q;
  assign pcm_out = data_q & ~cfg_mute;

endmodule

// File: rtl/pcm_slot_codec_chk.sv
module pcm_slot_codec_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_slave,
  input logic cfg_mute,
  input logic cfg_tri_en,
  input logic bclk_o,
  input logic sync_o,
  input logic pcm_out,
  input logic pcm_oe,
  input logic rx_valid
);

  p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_mute_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mute |-> !pcm_out);

  p_drive_cont_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_tri_en |-> pcm_oe);

  p_sync_on_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_slave && $rose(sync_o)) |-> $rose(bclk_o));

  p_out_on_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_slave && $stable(cfg_slave) && $stable(cfg_mute) && !$stable(pcm_out)) |-> $rose(bclk_o));

  p_slave_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_slave && $past(cfg_slave)) |-> (!bclk_o && !sync_o));

endmodule

bind pcm_slot_codec pcm_slot_codec_chk i_chk (.*);

// File: tb/test_pcm_slot_codec.sv
`timescale 1ns/1ps
module test_pcm_slot_codec;
  localparam int HALF = 2;
  localparam int FRM  = 32;

  logic clk = 0, rst_n = 0;
  logic cfg_slave = 0, cfg_sext = 0, cfg_lsb_first = 0, cfg_mute = 0, cfg_tri_en = 0, cfg_tri_rise = 0;
  logic [1:0] cfg_fmt = 2'b01;
  logic [15:0] tx_sample = 16'h0000;
  logic tx_take, rx_valid, bclk_o, sync_o, pcm_out, pcm_oe, pcm_in;
  logic ext_bclk = 0, ext_sync = 0;
  logic [15:0] rx_sample;

  assign pcm_in = pcm_out;
  always #10 clk = ~clk;

  pcm_slot_codec #(.CLK_HALF(HALF), .FRAME_BITS(FRM)) i_pcm_slot_codec (.*);

  int checks = 0, errors = 0;
  string tag = "R1";
  bit run_model = 0, slave_run = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] ref_word(input logic [1:0] f, input logic sx, input logic [15:0] s);
    int v;
    case (f)
      2'd0: begin v = int'(s[12:0]); if (sx && v >= 4096) v -= 8192; return sx ? 16'(v) : 16'(v * 8); end
      2'd1: return s;
      2'd2: begin v = int'(s[7:0]); if (sx && v >= 128) v -= 256; return sx ? 16'(v) : 16'(v * 256); end
      default: return {8'h00, s[7:0]};
    endcase
  endfunction

  function automatic logic [15:0] ref_rx(input logic [1:0] f, input logic [15:0] s);
    case (f)
      2'd0: return s & 16'h1FFF;
      2'd1: return s;
      default: return s & 16'h00FF;
    endcase
  endfunction

  // behavioural reference model, stepped on every falling clk edge
  bit m_pb, m_ps, m_pend, m_act, m_drv, m_bit, m_lsb;
  int m_idx, m_len, since, rx_wait, clk_n, last_rise, bits_n, last_sync;
  logic [1:0] m_fmt;
  logic [15:0] m_word, m_tx, m_exp_rx;

  task automatic model_reset();
    m_pb = 0; m_ps = 0; m_pend = 0; m_act = 0; m_drv = 0; m_bit = 0;
    m_idx = 0; m_len = 16; since = 0; rx_wait = 0; last_rise = -1; bits_n = 0; last_sync = -1;
  endtask

  function automatic bit slot_bit(input int k);
    return m_lsb ? m_word[k] : m_word[m_len - 1 - k];
  endfunction

  always @(negedge clk) begin
    clk_n++;
    if (run_model && rst_n) begin
      automatic bit b = cfg_slave ? ext_bclk : bclk_o;
      automatic bit s = cfg_slave ? ext_sync : sync_o;
      since++;
      if (b && !m_pb) begin
        since = 0;
        bits_n++;
        if (!cfg_slave) begin
          if (last_rise >= 0) chk(clk_n - last_rise == 2 * HALF, "R11", "bclk period", clk_n - last_rise, 2 * HALF);
          last_rise = clk_n;
          if (sync_o && last_sync >= 0) chk(bits_n - last_sync == FRM, "R11", "sync period", bits_n - last_sync, FRM);
          if (sync_o) last_sync = bits_n;
        end
        if (m_pend) begin
          m_pend = 0; m_act = 1; m_idx = 0; m_drv = 1; m_bit = slot_bit(0);
        end else if (m_act) begin
          if (m_idx == m_len - 1) begin
            m_act = 0; m_bit = 0;
            if (cfg_tri_en && cfg_tri_rise) m_drv = 0;
          end else begin
            m_idx++; m_bit = slot_bit(m_idx);
          end
        end
      end
      if (!b && m_pb) begin
        automatic bit st = s && !m_ps;
        since = 0;
        m_ps = s;
        if (m_act && m_idx == m_len - 1) begin
          rx_wait = 1;
          m_exp_rx = cfg_mute ? 16'h0 : ref_rx(m_fmt, m_tx);
          if (cfg_tri_en && !cfg_tri_rise && !st) m_drv = 0;
        end
        if (st) begin
          m_pend = 1; m_fmt = cfg_fmt; m_tx = tx_sample; m_lsb = cfg_lsb_first;
          m_len = (cfg_fmt == 2'b11) ? 8 : 16;
          m_word = ref_word(cfg_fmt, cfg_sext, tx_sample);
        end
      end
      m_pb = b;
      if (!cfg_slave || since >= 4) begin
        chk(pcm_out == (m_bit & !cfg_mute), tag, "pcm_out", pcm_out, m_bit & !cfg_mute);
        chk(pcm_oe == (!cfg_tri_en || m_drv), tag, "pcm_oe", pcm_oe, !cfg_tri_en || m_drv);
      end
      if (rx_valid) begin
        chk(rx_wait != 0, "R10", "unexpected rx_valid", 1, 0);
        if (rx_wait != 0) chk(rx_sample == m_exp_rx, "R10", {"rx_sample ", tag}, rx_sample, m_exp_rx);
        rx_wait = 0;
      end else if (rx_wait != 0) begin
        rx_wait++;
        if (rx_wait > 8) begin
          chk(0, "R10", "missing rx_valid", 0, 1);
          rx_wait = 0;
        end
      end
    end
  end

  // external bit clock and sync for slave mode: 16-bit frames
  int sbit = 0;
  initial begin
    forever begin
      repeat (6) @(posedge clk);
      #3;
      if (slave_run) begin
        ext_bclk = ~ext_bclk;
        if (ext_bclk) begin
          sbit = (sbit + 1) % 16;
          ext_sync = (sbit == 0);
        end
      end
    end
  end

  task automatic wait_frames(input int n);
    for (int i = 0; i < n; i++) begin
      do @(negedge clk); while (!rx_valid);
    end
    @(posedge clk); #3;
  endtask

  task automatic set_case(input logic [1:0] f, input bit sx, input bit lsb, input bit mute,
                          input bit tri_en, input bit tri_r, input logic [15:0] smp, input string t);
    cfg_fmt = f; cfg_sext = sx; cfg_lsb_first = lsb; cfg_mute = mute;
    cfg_tri_en = tri_en; cfg_tri_rise = tri_r; tx_sample = smp; tag = t;
    wait_frames(3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    chk(pcm_oe == 1, "R6", "reset pcm_oe", pcm_oe, 1);
    chk(rx_valid == 0, "R10", "reset rx_valid", rx_valid, 0);
    chk(bclk_o == 0 && sync_o == 0, "R11", "reset clock/sync", {bclk_o, sync_o}, 0);
    chk(pcm_out == 0, "R9", "reset pcm_out", pcm_out, 0);
    @(posedge clk); #3;
    rst_n = 1; run_model = 1;
    tag = "R1 R6 R9";
    wait_frames(1);
    set_case(2'b01, 0, 0, 0, 0, 0, 16'hA5C3, "R1 R6 R9");
    set_case(2'b01, 0, 1, 0, 0, 0, 16'hA5C3, "R4");
    set_case(2'b00, 0, 0, 0, 0, 0, 16'h1ABC, "R2");
    set_case(2'b00, 1, 0, 0, 0, 0, 16'h1ABC, "R3");
    set_case(2'b00, 1, 1, 0, 0, 0, 16'h0A3C, "R3 R4");
    set_case(2'b10, 0, 0, 0, 0, 0, 16'h009A, "R2");
    set_case(2'b10, 1, 0, 0, 0, 0, 16'h009A, "R3");
    set_case(2'b10, 1, 1, 0, 0, 0, 16'h0041, "R3 R4");
    set_case(2'b11, 0, 1, 0, 0, 0, 16'h00C6, "R1 R4");
    set_case(2'b01, 0, 0, 1, 0, 0, 16'hFFFF, "R5");
    set_case(2'b01, 0, 0, 0, 1, 0, 16'h6E17, "R7");
    set_case(2'b01, 0, 0, 0, 1, 1, 16'h6E17, "R7");
    set_case(2'b11, 0, 0, 0, 1, 1, 16'h0093, "R1 R7");
    // slave mode with back-to-back 16-bit frames
    run_model = 0;
    rst_n = 0;
    cfg_slave = 1;
    cfg_fmt = 2'b01; cfg_tri_en = 1; cfg_tri_rise = 0; cfg_mute = 0; cfg_lsb_first = 0;
    repeat (3) @(posedge clk); #3;
    model_reset();
    slave_run = 1;
    rst_n = 1; run_model = 1;
    tag = "R12 R8";
    repeat (6) @(negedge clk);
    chk(bclk_o == 0 && sync_o == 0, "R12", "slave clock/sync outputs", {bclk_o, sync_o}, 0);
    @(posedge clk); #3;
    wait_frames(1);
    set_case(2'b01, 0, 0, 0, 1, 0, 16'hC35A, "R12 R8");
    set_case(2'b01, 0, 1, 0, 1, 1, 16'h3C96, "R12 R8");
    set_case(2'b00, 1, 0, 0, 1, 0, 16'h1F01, "R12 R3");
    set_case(2'b11, 0, 0, 0, 1, 0, 16'h00B4, "R12 R7");
    set_case(2'b11, 0, 0, 0, 1, 1, 16'h00B4, "R12 R7");
    run_model = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule